// File: doc/BRIEF.md
# Multichannel Audio Link Subframe Aligner

This block sits behind a locked serial deserializer that has already undone the line coding. It receives one item per handshake: either a data byte or a JK sync symbol. It recovers aligned 32-bit channel samples. Each sample comes out with a 6-bit channel index and a flag that marks the first channel of an audio frame. A JK sync symbol that arrives between subframes while the block is aligned is legal filler. It is reported as a one-cycle strobe and is not treated as data.

Alignment starts from a hunting state. The block acquires alignment only when a JK sync is immediately followed by a data byte with the frame-sync bit set. While aligned, it returns to hunting in three cases:
- a sync symbol appears inside a subframe;
- a frame grows past 64 subframes;
- the lock input falls.

Both streams use valid/ready. An input item is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle: `!out_valid || out_ready`. A finished sample stays in the output register, unchanged, until `out_ready` is seen high. While the sample is held that way, input is stalled.

Top module: `sf_aligner`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `aligned`, `sync_strobe`, `align_err` and `ovf_err` are 0 and `in_ready` is 1.
- R2: While hunting, data bytes are discarded. A taken sync followed at once by a taken data byte with bit 3 (the frame-sync bit) set begins a subframe and raises `aligned`. If that next data byte has bit 3 clear, hunting continues and no sample is produced.
- R3: A subframe is four consecutively taken data bytes. The first byte lands in bits 31:24 of `out_sample` and the last in bits 7:0. `out_valid` rises in the cycle after the fourth byte is taken.
- R4: A sync taken after one, two or three bytes of a subframe discards the partial sample. It pulses `align_err` for one cycle and returns the block to hunting. A frame-sync data byte taken while hunting produces nothing.
- R5: A sync taken while aligned between subframes pulses `sync_strobe` for exactly one cycle, in the cycle after it is taken. Alignment is kept.
- R6: A subframe whose first byte has bit 3 set carries `out_chan` 0 and `out_first` 1. Each later subframe of the same frame carries the previous index plus one, with `out_first` 0.
- R7: Frames of any length from 1 to 64 subframes are accepted with no error. The next frame-sync subframe restarts the index at 0.
- R8: If the first byte of a 65th subframe arrives without bit 3 set, `ovf_err` pulses for one cycle, no sample is produced, and the block returns to hunting.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_sample`, `out_chan` and `out_first` hold their values and `in_ready` is 0.
- R10: With `lock_i` low, taken items are discarded and `aligned` is 0 from the next cycle. A fourth subframe byte taken while `lock_i` is low yields no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Deserializer locked |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item can be taken |
| in_sync | input | 1 | Item is a JK sync symbol (1) or a data byte (0) |
| in_byte | input | 8 | Data byte, bit 3 = frame-sync |
| out_valid | output | 1 | Sample valid |
| out_ready | input | 1 | Sample consumer ready |
| out_sample | output | 32 | Assembled sample, first byte in the top bits |
| out_chan | output | 6 | Channel index within the frame |
| out_first | output | 1 | Sample is channel 0 of a frame |
| sync_strobe | output | 1 | Sync seen between subframes |
| align_err | output | 1 | Sync inside a subframe, alignment dropped |
| ovf_err | output | 1 | Frame longer than 64 subframes |
| aligned | output | 1 | Block is aligned to subframes |

## Verification
Lock loss and subframe completion can land in the same cycle: the fourth byte of a subframe can be taken in the very cycle `lock_i` falls. The bench provokes this by driving `lock_i` low together with that byte. It judges the outcome at the ports: no sample may appear, and `aligned` must be low in the next cycle. A random output back-pressure also makes a finished sample wait for `out_ready` while the next item is presented. The bench checks that the held sample stays unchanged and that nothing is lost or duplicated.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,  // looking for a JK sync
    ST_CHKFS  = 2'd1,  // sync seen, need a frame-sync data byte
    ST_GATHER = 2'd2,  // inside a subframe
    ST_GAP    = 2'd3   // between subframes
  } sfa_state_e;

  localparam int FS_BIT = 3;
endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl #(
  parameter int BYTES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic take,
  input  logic is_sync,
  input  logic is_fs,
  input  logic chan_full,
  output logic begin_sf,
  output logic acc_byte,
  output logic fin,
  output logic aligned,
  output logic sync_strobe,
  output logic align_err,
  output logic ovf_err
);
  import sfa_pkg::*;
  localparam int CNT_W = $clog2(BYTES);

  sfa_state_e state, nxt;
  logic [CNT_W-1:0] cnt;
  logic s_st, e_al, e_ov;

  always_comb begin
    nxt      = state;
    begin_sf = 1'b0;
    acc_byte = 1'b0;
    fin      = 1'b0;
    s_st     = 1'b0;
    e_al     = 1'b0;
    e_ov     = 1'b0;
    if (!lock_i) begin
      nxt = ST_HUNT;
    end else if (take) begin
      unique case (state)
        ST_HUNT:  if (is_sync) nxt = ST_CHKFS;
        ST_CHKFS: if (!is_sync) begin
          if (is_fs) begin
            nxt = ST_GATHER; begin_sf = 1'b1; acc_byte = 1'b1;
          end else begin
            nxt = ST_HUNT;
          end
        end
        ST_GATHER: if (is_sync) begin
          nxt = ST_HUNT; e_al = 1'b1;
        end else begin
          acc_byte = 1'b1;
          if (cnt == CNT_W'(BYTES - 1)) begin
            fin = 1'b1; nxt = ST_GAP;
          end
        end
        ST_GAP: if (is_sync) begin
          s_st = 1'b1;
        end else if (!is_fs && chan_full) begin
          e_ov = 1'b1; nxt = ST_HUNT;
        end else begin
          begin_sf = 1'b1; acc_byte = 1'b1; nxt = ST_GATHER;
        end
        default: nxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      cnt         <= '0;
      sync_strobe <= 1'b0;
      align_err   <= 1'b0;
      ovf_err     <= 1'b0;
    end else begin
      state       <= nxt;
      sync_strobe <= s_st;
      align_err   <= e_al;
      ovf_err     <= e_ov;
      if (begin_sf)      cnt <= CNT_W'(1);
      else if (acc_byte) cnt <= cnt + 1'b1;
    end
  end

  assign aligned = (state == ST_GATHER) || (state == ST_GAP);

  AST_UNLOCK_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> !aligned);  // R10
  AST_SYNC_KEEPS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    sync_strobe |-> aligned);  // R5
  AST_ALIGN_ERR_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !aligned && !sync_strobe);  // R4
  AST_OVF_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> !aligned && !align_err);  // R8
endmodule

// File: rtl/sfa_chan.sv
module sfa_chan #(
  parameter int MAX_SF = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       begin_sf,
  input  logic                       is_fs,
  output logic [$clog2(MAX_SF)-1:0]  chan,
  output logic                       first,
  output logic                       full
);
  localparam int CHAN_W = $clog2(MAX_SF);
  localparam int NS_W   = $clog2(MAX_SF + 1);

  logic [NS_W-1:0] nseen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nseen <= '0;
      chan  <= '0;
      first <= 1'b0;
    end else if (begin_sf) begin
      first <= is_fs;
      if (is_fs) begin
        chan  <= '0;
        nseen <= NS_W'(1);
      end else begin
        chan  <= nseen[CHAN_W-1:0];
        nseen <= nseen + 1'b1;
      end
    end
  end

  assign full = (nseen == NS_W'(MAX_SF));

  AST_NSEEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nseen <= NS_W'(MAX_SF));  // R7
endmodule

// File: rtl/sfa_pack.sv
module sfa_pack #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  parameter int CHAN_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_byte,
  input  logic                    fin,
  input  logic [BYTE_W-1:0]       din,
  input  logic [CHAN_W-1:0]       chan,
  input  logic                    first,
  input  logic                    out_ready,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic [BYTE_W*BYTES-1:0] out_sample,
  output logic [CHAN_W-1:0]       out_chan,
  output logic                    out_first
);
  localparam int SAMPLE_W = BYTE_W * BYTES;
  localparam int KEEP_W   = SAMPLE_W - BYTE_W;

  logic [SAMPLE_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr         <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_chan   <= '0;
      out_first  <= 1'b0;
    end else begin
      if (acc_byte) sr <= {sr[KEEP_W-1:0], din};
      if (fin) begin
        out_valid  <= 1'b1;
        out_sample <= {sr[KEEP_W-1:0], din};
        out_chan   <= chan;
        out_first  <= first;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  assign in_ready = !out_valid || out_ready;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample)
      && $stable(out_chan) && $stable(out_first));  // R9
endmodule

// File: rtl/sf_aligner.sv
module sf_aligner #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  parameter int MAX_SF = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lock_i,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_sync,
  input  logic [BYTE_W-1:0]             in_byte,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BYTE_W*BYTES-1:0]       out_sample,
  output logic [$clog2(MAX_SF)-1:0]     out_chan,
  output logic                          out_first,
  output logic                          sync_strobe,
  output logic                          align_err,
  output logic                          ovf_err,
  output logic                          aligned
);
  localparam int CHAN_W = $clog2(MAX_SF);

  logic take, begin_sf, acc_byte, fin, chan_full, cur_first;
  logic [CHAN_W-1:0] cur_chan;

  assign take = in_valid && in_ready;

  sfa_ctrl #(.BYTES(BYTES)) u_ctrl (
    .clk, .rst_n, .lock_i, .take,
    .is_sync(in_sync), .is_fs(in_byte[sfa_pkg::FS_BIT]), .chan_full,
    .begin_sf, .acc_byte, .fin, .aligned, .sync_strobe, .align_err, .ovf_err
  );

  sfa_chan #(.MAX_SF(MAX_SF)) u_chan (
    .clk, .rst_n, .begin_sf, .is_fs(in_byte[sfa_pkg::FS_BIT]),
    .chan(cur_chan), .first(cur_first), .full(chan_full)
  );

  sfa_pack #(.BYTE_W(BYTE_W), .BYTES(BYTES), .CHAN_W(CHAN_W)) u_pack (
    .clk, .rst_n, .acc_byte, .fin, .din(in_byte), .chan(cur_chan),
    .first(cur_first), .out_ready, .in_ready, .out_valid, .out_sample,
    .out_chan, .out_first
  );

  AST_FIRST_IS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_first == (out_chan == '0)));  // R6
endmodule

// File: tb/tb_sf_aligner.sv
module tb_sf_aligner;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, lock_i = 1'b0;
  logic in_valid = 1'b0, in_sync = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, out_valid, out_first, sync_strobe, align_err, ovf_err, aligned;
  logic [31:0] out_sample;
  logic [5:0]  out_chan;

  sf_aligner dut (
    .clk, .rst_n, .lock_i, .in_valid, .in_ready, .in_sync, .in_byte,
    .out_valid, .out_ready, .out_sample, .out_chan, .out_first,
    .sync_strobe, .align_err, .ovf_err, .aligned
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int sync_seen = 0, aerr_seen = 0, oerr_seen = 0, exp_sync = 0;
  logic [38:0] exp_q[$];
  bit prev_stall = 0;
  logic [38:0] prev_out;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lead_byte(logic [7:0] r, bit fs);
    return fs ? (r | 8'h08) : (r & 8'hF7);
  endfunction

  function automatic logic [38:0] exp_entry(bit fs, int ch, logic [31:0] w);
    return {fs, 6'(ch), w};
  endfunction

  // output side: random back-pressure, scoreboard, pulse counters
  always @(negedge clk) begin
    out_ready = ($urandom % 4) != 0;
    #1;
    if (rst_n) begin
      if (sync_strobe) sync_seen++;
      if (align_err)   aerr_seen++;
      if (ovf_err)     oerr_seen++;
      if (prev_stall) begin
        check(out_valid, "R9 held valid", 64'(out_valid), 64'd1);
        check({out_first, out_chan, out_sample} == prev_out, "R9 held sample",
              64'({out_first, out_chan, out_sample}), 64'(prev_out));
        check(!in_ready || out_ready, "R9 in_ready", 64'(in_ready), 64'd0);
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_first, out_chan, out_sample};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected sample", 64'(out_sample), 64'd0);
        end else begin
          logic [38:0] e;
          e = exp_q.pop_front();
          check(out_sample == e[31:0], "R3 sample", 64'(out_sample), 64'(e[31:0]));
          check(out_chan == e[37:32], "R6 chan", 64'(out_chan), 64'(e[37:32]));
          check(out_first == e[38], "R6 first", 64'(out_first), 64'(e[38]));
        end
      end
    end
  end

  task automatic send(bit s, logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_sync = s; in_byte = b;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_sf(int ch, bit expect_out);
    logic [31:0] w;
    w = $urandom;
    w[31:24] = lead_byte(w[31:24], ch == 0);
    send(0, w[31:24]); send(0, w[23:16]); send(0, w[15:8]); send(0, w[7:0]);
    if (expect_out) exp_q.push_back(exp_entry(ch == 0, ch, w));
  endtask

  task automatic send_frame(int nch, bit right_after_acq);
    for (int ch = 0; ch < nch; ch++) begin
      if (!(ch == 0 && right_after_acq)) begin
        int k = $urandom % 3;
        for (int j = 0; j < k; j++) begin send(1, 8'($urandom)); exp_sync++; end
      end
      send_sf(ch, 1);
    end
  endtask

  task automatic drain_and_check(string tag);
    idle(12);
    check(exp_q.size() == 0, {"R3 drained ", tag}, 64'(exp_q.size()), 64'd0);
    check(sync_seen == exp_sync, {"R5 strobes ", tag}, 64'(sync_seen), 64'(exp_sync));
  endtask

  task automatic drop_lock();
    @(negedge clk); lock_i = 1'b0; in_valid = 1'b0;
    @(negedge clk); #3;
    check(!aligned, "R10 aligned low", 64'(aligned), 64'd0);
    lock_i = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int a0, o0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #3;
    check(!out_valid && !aligned && in_ready, "R1 reset outs",
          64'({out_valid, aligned, in_ready}), 64'b001);
    check(!sync_strobe && !align_err && !ovf_err, "R1 reset pulses",
          64'({sync_strobe, align_err, ovf_err}), 64'd0);
    @(negedge clk); rst_n = 1'b1; lock_i = 1'b1;

    // R2: hunting ignores data; sync + non-frame-sync byte rejected
    send(0, 8'h08); send(0, 8'h5A); send(1, 8'h00); send(0, 8'h10);
    send(0, 8'h08); send(0, 8'h11); send(0, 8'h22); send(0, 8'h33);
    idle(2); #3;
    check(!aligned, "R2 rejected acquisition", 64'(aligned), 64'd0);

    // random frames
    for (int it = 0; it < 25; it++) begin
      int ng = $urandom % 6;
      for (int g = 0; g < ng; g++) send(0, 8'($urandom));
      send(1, 8'($urandom));
      for (int f = 0; f < 1 + int'($urandom % 3); f++)
        send_frame(1 + int'($urandom % 64), f == 0);
      idle(1); #3;
      check(aligned, "R2 aligned after acquisition", 64'(aligned), 64'd1);
      drain_and_check("random");
      drop_lock();
    end

    // R7 full 64-channel frames back to back, then R8 overflow
    send(1, 8'h00);
    send_frame(64, 1);
    send_frame(64, 0);
    o0 = oerr_seen;
    send(0, 8'h20);
    idle(2); #3;
    check(oerr_seen == o0 + 1, "R8 overflow pulse", 64'(oerr_seen), 64'(o0 + 1));
    check(!aligned, "R8 back to hunting", 64'(aligned), 64'd0);
    send(0, 8'h21); send(0, 8'h22); send(0, 8'h23);
    drain_and_check("R7 R8");

    // R4 sync inside a subframe
    send(1, 8'h00);
    send_sf(0, 1);
    a0 = aerr_seen;
    send(0, 8'h01); send(0, 8'h02); send(1, 8'h00);
    idle(2); #3;
    check(aerr_seen == a0 + 1, "R4 align_err pulse", 64'(aerr_seen), 64'(a0 + 1));
    check(!aligned, "R4 hunting", 64'(aligned), 64'd0);
    send(0, 8'h08); send(0, 8'h44); send(0, 8'h55); send(0, 8'h66);
    drain_and_check("R4");

    // R10 collision: lock falls with the fourth byte
    send(1, 8'h00);
    send_sf(0, 1);
    send(0, 8'h70); send(0, 8'h71); send(0, 8'h72);
    @(negedge clk);
    lock_i = 1'b0; in_valid = 1'b1; in_sync = 1'b0; in_byte = 8'h73;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(negedge clk); in_valid = 1'b0; #3;
    check(!aligned, "R10 collision aligned", 64'(aligned), 64'd0);
    lock_i = 1'b1;
    drain_and_check("R10");

    // R5 + R6 directed: syncs between, short frame then new frame
    send(1, 8'h00);
    send_sf(0, 1);
    send(1, 8'h00); exp_sync++;
    send(1, 8'h00); exp_sync++;
    send_sf(1, 1);
    send_sf(0, 1);
    idle(1); #3;
    check(aligned, "R5 alignment kept", 64'(aligned), 64'd1);
    drain_and_check("R5 R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule